// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Non-Maskable Request

This block sits between a set of peripheral interrupt request lines and a small processor core. It picks one winner among the maskable lines and signals it to the core. When the core acknowledges, it hands over a vector number. It keeps a record of which priority levels are being serviced, so that nested interrupts preempt only when they are of strictly higher priority. Software sets a mask bit for each line and a global enable flag through a small write port. A return strobe from the core closes the innermost service level.

A separate non-maskable request is detected on its rising edge and latched. This request is not affected by the global flag or by any mask bit. It preempts any maskable service in progress and is delivered with a fixed handler address instead of a table vector. While it is being serviced, a flag output tells the core so.

The sequencer has three states. In IDLE it waits: the transition "raise" goes to REQ when any candidate wins. In REQ the interrupt output is high. The transition "take" goes to GRANT when the core acknowledges. The transition "drop" goes back to IDLE when the winner disappears before the acknowledge. From GRANT the transition "settle" always returns to IDLE one cycle later.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While the global enable (written with wr_sel_i=1, from wr_data_i bit 0) is 0, no maskable line raises irq_o. A line still held high is signalled once the flag is set to 1.
- R2: A line whose mask bit is 1 (written with wr_sel_i=0, bit i masking line i) is never signalled or serviced. The other lines are unaffected.
- R3: Among the eligible lines, the lowest index wins. Line 0 has the highest priority.
- R4: On the cycle after an acknowledge of a maskable winner, vec_o equals VEC_BASE plus the winning line index. vec_o holds that value until the next acknowledge.
- R5: A maskable line is held off while a line of the same or higher priority is in service. A line of strictly higher priority preempts a lower one that is in service.
- R6: The non-maskable request ignores the global enable and all masks. It preempts maskable service. After its acknowledge, vec_o equals NMI_ADDR and nmi_taken_o is 1 until its return.
- R7: The non-maskable input is edge triggered. One rising edge gives exactly one service, however long the input stays high.
- R8: A pulse on reti_i clears the highest-priority in-service level, the non-maskable level first. Pending requests of lower priority then become eligible again.
- R9: A maskable request that is withdrawn before the acknowledge makes irq_o fall on the next cycle and is never serviced.
- R10: After reset, irq_o, vec_o and nmi_taken_o are 0, every mask bit is 0 and the global enable is 0.
- R11: irq_o rises on the clock edge after a winning request is present. After an acknowledge, irq_o is low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_LINES | Level-sensitive maskable requests; index 0 has the highest priority |
| nmi_i | input | 1 | Non-maskable request, taken on its rising edge |
| ack_i | input | 1 | Acknowledge from the core, honoured while irq_o is high |
| reti_i | input | 1 | Return-from-interrupt pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the mask register, 1 selects the global enable |
| wr_data_i | input | N_LINES | Write data |
| irq_o | output | 1 | Interrupt signal to the core |
| vec_o | output | ADDR_W | Vector number or fixed non-maskable handler address |
| nmi_taken_o | output | 1 | High while the non-maskable service is in progress |

## Verification
The assertions assume the core follows the handshake. It acknowledges only while irq_o is high. It does not send a return strobe in the same cycle as an acknowledge. It sends a return strobe only for a level that it actually entered. The stimulus keeps to these rules: ack_i and reti_i are each driven as single-cycle pulses from separate tasks, and an acknowledge is issued only after irq_o has been sampled high. The bench's own model of the in-service levels follows the same retire order as the block.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_GRANT = 2'd2
    } irq_state_e;

    localparam logic WSEL_MASK = 1'b0;
    localparam logic WSEL_GIE  = 1'b1;

endpackage

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
    parameter int N = 8,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec_i,
    output logic         found_o,
    output logic [W-1:0] idx_o
);

    // Lowest set index wins: scan from the top so lower indices override.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic clr_i,
    output logic pend_o
);

    logic nmi_q;
    logic rise;

    assign rise = nmi_i & ~nmi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q  <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            nmi_q <= nmi_i;
            if (rise) begin
                pend_o <= 1'b1;
            end else if (clr_i) begin
                pend_o <= 1'b0;
            end
        end
    end

    // R7: a pending flag only appears after a fresh rising edge
    a_r7_one_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> ($past(nmi_i) && !$past(nmi_q)));

endmodule

// File: rtl/irq_service_stack.sv
module irq_service_stack #(
    parameter int N = 8,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en_i,
    input  logic         set_nmi_i,
    input  logic [W-1:0] set_idx_i,
    input  logic         ret_i,
    output logic [N:0]   isr_o,
    output logic         top_found_o,
    output logic [W-1:0] top_idx_o
);

    logic [N:0] isr_q;
    logic [N:0] isr_d;

    irq_prio_find #(.N(N), .W(W)) u_top_find (
        .vec_i  (isr_q[N-1:0]),
        .found_o(top_found_o),
        .idx_o  (top_idx_o)
    );

    always_comb begin
        isr_d = isr_q;
        if (ret_i) begin
            if (isr_q[N]) begin
                isr_d[N] = 1'b0;
            end else if (top_found_o) begin
                isr_d[top_idx_o] = 1'b0;
            end
        end
        if (set_en_i) begin
            if (set_nmi_i) begin
                isr_d[N] = 1'b1;
            end else begin
                isr_d[set_idx_i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= isr_d;
        end
    end

    assign isr_o = isr_q;

    // R5: a maskable entry only nests above strictly lower-priority service
    a_r5_nest_order: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en_i && !set_nmi_i && !ret_i) |->
            (!isr_q[N] && (!top_found_o || (set_idx_i < top_idx_o))));

    // R8: a return retires exactly one level
    a_r8_one_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !set_en_i && (isr_q != '0)) |=>
            ($countones(isr_q) == $countones($past(isr_q)) - 1));

    // R8: the non-maskable level is retired before any maskable one
    a_r8_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !set_en_i && isr_q[N]) |=>
            (!isr_q[N] && (isr_q[N-1:0] == $past(isr_q[N-1:0]))));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int                N_LINES  = 8,
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0020,
    parameter logic [ADDR_W-1:0] NMI_ADDR = 16'hFFF0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_i,
    input  logic               nmi_i,
    input  logic               ack_i,
    input  logic               reti_i,
    input  logic               wr_en_i,
    input  logic               wr_sel_i,
    input  logic [N_LINES-1:0] wr_data_i,
    output logic               irq_o,
    output logic [ADDR_W-1:0]  vec_o,
    output logic               nmi_taken_o
);

    localparam int W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    irq_state_e state_q, state_d;

    logic [N_LINES-1:0] mask_q;
    logic               gie_q;
    logic [N_LINES-1:0] elig;
    logic               m_found;
    logic [W-1:0]       m_idx;
    logic [N_LINES:0]   isr;
    logic               s_found;
    logic [W-1:0]       s_idx;
    logic               nmi_pend;
    logic               nmi_ok;
    logic               mask_ok;
    logic               any_win;
    logic               take;
    logic               take_nmi;
    logic               take_mask;

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            gie_q  <= 1'b0;
        end else if (wr_en_i) begin
            if (wr_sel_i == WSEL_MASK) begin
                mask_q <= wr_data_i;
            end else begin
                gie_q <= wr_data_i[0];
            end
        end
    end

    assign elig = irq_i & ~mask_q & {N_LINES{gie_q}};

    irq_prio_find #(.N(N_LINES), .W(W)) u_req_find (
        .vec_i  (elig),
        .found_o(m_found),
        .idx_o  (m_idx)
    );

    irq_nmi_latch u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .nmi_i (nmi_i),
        .clr_i (take_nmi),
        .pend_o(nmi_pend)
    );

    irq_service_stack #(.N(N_LINES), .W(W)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en_i   (take),
        .set_nmi_i  (take_nmi),
        .set_idx_i  (m_idx),
        .ret_i      (reti_i),
        .isr_o      (isr),
        .top_found_o(s_found),
        .top_idx_o  (s_idx)
    );

    assign nmi_ok  = nmi_pend & ~isr[N_LINES];
    assign mask_ok = m_found & ~isr[N_LINES] & (~s_found | (m_idx < s_idx));
    assign any_win = nmi_ok | mask_ok;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: raise, take, drop, settle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_win) state_d = ST_REQ;
            ST_REQ: begin
                if (!any_win)   state_d = ST_IDLE;
                else if (ack_i) state_d = ST_GRANT;
            end
            ST_GRANT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and grant strobes
    always_comb begin
        irq_o     = (state_q == ST_REQ);
        take      = (state_q == ST_REQ) & ack_i & any_win;
        take_nmi  = take & nmi_ok;
        take_mask = take & ~nmi_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_o <= '0;
        end else if (take_nmi) begin
            vec_o <= NMI_ADDR;
        end else if (take_mask) begin
            vec_o <= VEC_BASE + ADDR_W'(m_idx);
        end
    end

    assign nmi_taken_o = isr[N_LINES];

    // R6: the non-maskable grant yields the fixed address and the taken flag
    a_r6_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ && ack_i && nmi_ok) |=> (vec_o == NMI_ADDR && nmi_taken_o));

    // R1/R2: a maskable grant needs the global flag, a clear mask bit and a live line
    a_r2_gate_open: assert property (@(posedge clk) disable iff (!rst_n)
        take_mask |-> (gie_q && !mask_q[m_idx] && irq_i[m_idx]));

    // R4: vector of a maskable grant is base plus the line index
    a_r4_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ && ack_i && mask_ok && !nmi_ok) |=>
            (vec_o == VEC_BASE + ADDR_W'($past(m_idx))));

    // R11: the request drops right after an acknowledge
    a_r11_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o);

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

    localparam int          N     = 8;
    localparam int          AW    = 16;
    localparam logic [15:0] VBASE = 16'h0020;
    localparam logic [15:0] NADDR = 16'hFFF0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_i = '0;
    logic          nmi_i = 1'b0;
    logic          ack_i = 1'b0;
    logic          reti_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic          wr_sel_i = 1'b0;
    logic [N-1:0]  wr_data_i = '0;
    logic          irq_o;
    logic [AW-1:0] vec_o;
    logic          nmi_taken_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [N:0]   isr_m = '0;
    logic [N-1:0] mask_m = '0;
    logic         gie_m = 1'b0;

    always #5 clk = ~clk;

    prio_irq_ctrl #(.N_LINES(N), .ADDR_W(AW), .VEC_BASE(VBASE), .NMI_ADDR(NADDR)) u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .nmi_i(nmi_i), .ack_i(ack_i),
        .reti_i(reti_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .irq_o(irq_o), .vec_o(vec_o), .nmi_taken_o(nmi_taken_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [N-1:0] d);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        cyc(1);
        wr_en_i = 1'b0;
        if (sel) gie_m = d[0]; else mask_m = d;
    endtask

    task automatic ack();
        ack_i = 1'b1;
        cyc(1);
        ack_i = 1'b0;
    endtask

    task automatic reti();
        reti_i = 1'b1;
        cyc(1);
        reti_i = 1'b0;
        if (isr_m[N]) begin
            isr_m[N] = 1'b0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (isr_m[i]) begin
                    isr_m[i] = 1'b0;
                    break;
                end
            end
        end
    endtask

    // Expected maskable winner from the requirements; -1 when none
    function automatic int exp_line(input logic [N-1:0] rq, input logic [N-1:0] mk,
                                    input logic ge, input logic [N:0] sv);
        int w = -1;
        int s = N;
        if (!ge || sv[N]) return -1;
        for (int i = N - 1; i >= 0; i--) begin
            if (rq[i] && !mk[i]) w = i;
            if (sv[i]) s = i;
        end
        if (w >= 0 && w < s) return w;
        return -1;
    endfunction

    initial begin
        void'($urandom(32'h5EED1234));
        cyc(2);
        // R10: reset state
        chk("R10 irq_o", {31'b0, irq_o}, 32'd0);
        chk("R10 vec_o", {16'b0, vec_o}, 32'd0);
        chk("R10 nmi_taken_o", {31'b0, nmi_taken_o}, 32'd0);
        rst_n = 1'b1;
        cyc(1);

        // R1: line 3 pending with the global flag clear
        irq_i = 8'b0000_1000;
        cyc(4);
        chk("R1 held while disabled", {31'b0, irq_o}, 32'd0);
        wr(1'b1, 8'h01);
        cyc(1);
        chk("R1 raised after enable", {31'b0, irq_o}, 32'd1);
        ack();
        isr_m[3] = 1'b1;
        chk("R4 vector line 3", {16'b0, vec_o}, 32'(VBASE + 3));
        chk("R11 low after ack", {31'b0, irq_o}, 32'd0);
        cyc(3);
        chk("R5 equal level held off", {31'b0, irq_o}, 32'd0);
        irq_i = 8'b0000_1010;
        cyc(2);
        chk("R5 higher preempts", {31'b0, irq_o}, 32'd1);
        ack();
        isr_m[1] = 1'b1;
        chk("R5 vector line 1", {16'b0, vec_o}, 32'(VBASE + 1));
        irq_i = 8'b0000_1000;
        reti();
        cyc(3);
        chk("R8 line 3 still in service", {31'b0, irq_o}, 32'd0);
        chk("R4 vector holds", {16'b0, vec_o}, 32'(VBASE + 1));
        reti();
        cyc(1);
        chk("R8 lower eligible after return", {31'b0, irq_o}, 32'd1);
        // R9: withdraw before acknowledge
        irq_i = '0;
        cyc(1);
        chk("R9 dropped request", {31'b0, irq_o}, 32'd0);
        cyc(3);
        chk("R9 stays idle", {31'b0, irq_o}, 32'd0);

        // R2 and R3: mask line 2, lines 2 and 6 request
        wr(1'b0, 8'b0000_0100);
        irq_i = 8'b0100_0100;
        cyc(2);
        ack();
        isr_m[6] = 1'b1;
        chk("R2 masked line skipped", {16'b0, vec_o}, 32'(VBASE + 6));
        irq_i = '0;
        reti();
        wr(1'b0, 8'h00);
        irq_i = 8'b1010_0100;
        cyc(2);
        ack();
        isr_m[2] = 1'b1;
        chk("R3 lowest index wins", {16'b0, vec_o}, 32'(VBASE + 2));
        irq_i = '0;
        reti();

        // R6: non-maskable request over a maskable service, with everything masked
        irq_i = 8'b0001_0000;
        cyc(2);
        ack();
        isr_m[4] = 1'b1;
        irq_i = '0;
        wr(1'b1, 8'h00);
        wr(1'b0, 8'hFF);
        nmi_i = 1'b1;
        cyc(3);
        chk("R6 nmi raises irq", {31'b0, irq_o}, 32'd1);
        ack();
        isr_m[N] = 1'b1;
        chk("R6 fixed handler address", {16'b0, vec_o}, 32'(NADDR));
        chk("R6 nmi taken flag", {31'b0, nmi_taken_o}, 32'd1);
        reti();
        chk("R8 nmi retired first", {31'b0, nmi_taken_o}, 32'd0);
        cyc(5);
        chk("R7 held input gives one service", {31'b0, irq_o}, 32'd0);
        nmi_i = 1'b0;
        cyc(1);
        nmi_i = 1'b1;
        cyc(3);
        chk("R7 new edge served", {31'b0, irq_o}, 32'd1);
        ack();
        isr_m[N] = 1'b1;
        nmi_i = 1'b0;
        reti();
        reti();
        chk("R8 all levels retired", {31'b0, nmi_taken_o}, 32'd0);

        // Random phase
        for (int it = 0; it < 300; it++) begin
            logic [N-1:0] rq;
            int w;
            if ($urandom_range(0, 3) == 0) reti();
            wr(1'b0, N'($urandom & $urandom & $urandom));
            rq = N'($urandom & $urandom);
            irq_i = rq;
            wr(1'b1, N'($urandom_range(0, 3) != 0));
            cyc(1);
            w = exp_line(rq, mask_m, gie_m, isr_m);
            chk("R3 random irq_o", {31'b0, irq_o}, {31'b0, (w >= 0)});
            if (w >= 0) begin
                ack();
                isr_m[w] = 1'b1;
                chk("R4 random vector", {16'b0, vec_o}, 32'(VBASE + 16'(w)));
                cyc(1);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule